// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block owns the program counter of a simple 32-bit, fixed-width-instruction core. Each cycle it looks at the instruction held at the current PC and at the two register operands that the instruction names. From these it works out the address of the next instruction. Ordinary instructions move on to the following word. The two conditional branch kinds compare the operands for equality or inequality and, when taken, jump by a signed word displacement. The unconditional jump replaces the low 28 bits of the PC with a 26-bit word index.

The surrounding pipeline supplies the instruction word and the operand values. It raises the step enable when the PC may advance. The `taken` output is combinational from the current instruction and operands, so a fetch stage can use it in the same cycle as a redirect hint. Instruction fetch, register reads and any delay-slot behaviour belong to other blocks.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the PC is loaded with the parameter `START_PC` (default 0x0040_0000), whatever the other inputs are.
- R2: When `step_en` is low, the PC keeps its value across the edge, even if the current instruction is a taken branch or a jump.
- R3: An instruction whose opcode (bits 31:26) is neither 0x02, 0x04 nor 0x05 advances the PC by 4, and `taken` is low.
- R4: Opcode 0x04 (branch-if-equal) with equal operands is taken. The new PC is PC + 4 + (sign-extended bits 15:0 shifted left by 2).
- R5: Opcode 0x04 with unequal operands is not taken, and the PC advances by 4.
- R6: Opcode 0x05 (branch-if-not-equal) is taken to the same target as R4 when the operands differ. When they are equal it is not taken and the PC advances by 4.
- R7: Opcode 0x02 (jump) is always taken. The new PC is {bits 31:28 of the jump's own PC, instruction bits 25:0, 2'b00}. The upper four bits come from the jump's own PC, not from PC + 4, and this matters when PC + 4 crosses a 256 MB boundary.
- R8: A negative displacement moves the PC backwards. The most negative displacement (0x8000) subtracts 0x20000 from PC + 4.
- R9: `taken` reflects the current instruction and operands in the same cycle, independent of `step_en`.
- R10: All PC arithmetic is modulo 2^32, so a backward branch below address zero wraps to the top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | PC may advance at this edge |
| instr | input | 32 | Instruction at the current PC |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| pc | output | 32 | Current program counter |
| taken | output | 1 | Current instruction redirects flow |

## Verification
A wrong internal PC value shows up on `pc` one edge after the step that produced it, and it stays wrong from then on. Every later sequential step carries the error forward. Decode or compare errors show up on `taken` in the same cycle, before any edge. The bench compares both outputs against a behavioural model on every cycle, so a fault is caught at most one clock after it arises. The check on the jump's upper bits needs a PC that sits just below a 256 MB boundary, and the bench reaches that point with a jump.

// File: rtl/pc_next_pkg.sv
// Package: shared opcode constants and flow-kind type for the next-PC unit.
// Assumes the opcode occupies instruction bits 31:26.
package pc_next_pkg;
    localparam int INSTR_W = 32;
    localparam int OPC_W   = 6;
    localparam int DISP_W  = 16;
    localparam int INDEX_W = 26;

    localparam logic [OPC_W-1:0] OPC_JUMP = 6'h02;
    localparam logic [OPC_W-1:0] OPC_BEQ  = 6'h04;
    localparam logic [OPC_W-1:0] OPC_BNE  = 6'h05;

    typedef enum logic [1:0] {
        FLOW_SEQ    = 2'd0,
        FLOW_BRANCH = 2'd1,
        FLOW_JUMP   = 2'd2
    } flow_kind_t;
endpackage

// File: rtl/pc_flow_decode.sv
// Module: classifies the opcode and resolves the branch condition.
// Assumes the operands are already the values the instruction names.
module pc_flow_decode
    import pc_next_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [OPC_W-1:0]  opcode,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output flow_kind_t        kind,
    output logic              redirect
);
    logic same;

    // Purpose: pick the flow kind and decide whether flow is redirected.
    always_comb begin
        same     = (op_a == op_b);
        kind     = FLOW_SEQ;
        redirect = 1'b0;
        unique case (opcode)
            OPC_JUMP: begin
                kind     = FLOW_JUMP;
                redirect = 1'b1;
            end
            OPC_BEQ: begin
                kind     = FLOW_BRANCH;
                redirect = same;
            end
            OPC_BNE: begin
                kind     = FLOW_BRANCH;
                redirect = !same;
            end
            default: begin
                kind     = FLOW_SEQ;
                redirect = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pc_target_calc.sv
// Module: forms the sequential, branch and jump addresses and selects one.
// Assumes PC_W >= 28 so the jump index fits under the kept upper bits.
module pc_target_calc
    import pc_next_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic [PC_W-1:0]    cur_pc,
    input  logic [INDEX_W-1:0] field_lo,
    input  flow_kind_t         kind,
    input  logic               redirect,
    output logic [PC_W-1:0]    next_pc
);
    localparam int KEEP_W = PC_W - INDEX_W - 2;
    localparam int EXT_W  = PC_W - DISP_W - 2;

    logic [PC_W-1:0] seq_addr;
    logic [PC_W-1:0] disp_bytes;
    logic [PC_W-1:0] branch_addr;
    logic [PC_W-1:0] jump_addr;

    // Purpose: compute every candidate address from the current PC.
    always_comb begin
        seq_addr    = cur_pc + PC_W'(4);
        disp_bytes  = {{EXT_W{field_lo[DISP_W-1]}}, field_lo[DISP_W-1:0], 2'b00};
        branch_addr = seq_addr + disp_bytes;
        jump_addr   = {cur_pc[PC_W-1 -: KEEP_W], field_lo, 2'b00};
    end

    // Purpose: choose the next address from the flow kind and condition.
    always_comb begin
        next_pc = seq_addr;
        if (redirect) begin
            if (kind == FLOW_JUMP) begin
                next_pc = jump_addr;
            end else if (kind == FLOW_BRANCH) begin
                next_pc = branch_addr;
            end
        end
    end
endmodule

// File: rtl/pc_next_unit.sv
// Module: top of the next-PC unit; holds the PC register.
// Assumes the instruction and operands are stable before each rising edge.
module pc_next_unit
    import pc_next_pkg::*;
#(
    parameter int          PC_W     = 32,
    parameter logic [31:0] START_PC = 32'h0040_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step_en,
    input  logic [INSTR_W-1:0]   instr,
    input  logic [PC_W-1:0]      rs_val,
    input  logic [PC_W-1:0]      rt_val,
    output logic [PC_W-1:0]      pc,
    output logic                 taken
);
    localparam logic [PC_W-1:0] RESET_ADDR = PC_W'(START_PC);

    flow_kind_t      kind;
    logic            redirect;
    logic [PC_W-1:0] next_pc;

    pc_flow_decode #(.DATA_W(PC_W)) u_decode (
        .opcode   (instr[INSTR_W-1 -: OPC_W]),
        .op_a     (rs_val),
        .op_b     (rt_val),
        .kind     (kind),
        .redirect (redirect)
    );

    pc_target_calc #(.PC_W(PC_W)) u_target (
        .cur_pc   (pc),
        .field_lo (instr[INDEX_W-1:0]),
        .kind     (kind),
        .redirect (redirect),
        .next_pc  (next_pc)
    );

    // Purpose: PC register with synchronous reset and step gating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= RESET_ADDR;
        end else if (step_en) begin
            pc <= next_pc;
        end
    end

    assign taken = redirect;

    // R2: no step means the PC does not move
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(step_en)) |-> (pc == $past(pc)));

    // R3: a non-redirecting step advances by exactly one word
    assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(step_en) && !$past(taken)) |-> (pc == $past(pc) + PC_W'(4)));

    // R4: equal operands on branch-if-equal always redirect
    assert_beq_equal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[31:26] == OPC_BEQ && rs_val == rt_val) |-> taken);

    // R6: equal operands on branch-if-not-equal never redirect
    assert_bne_equal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[31:26] == OPC_BNE && rs_val == rt_val) |-> !taken);

    // R7: a jump is always taken and keeps the upper PC bits of the jump itself
    assert_jump_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[31:26] == OPC_JUMP) |-> taken);

    assert_jump_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(step_en) && $past(instr[31:26]) == OPC_JUMP)
            |-> (pc[PC_W-1 -: 4] == $past(pc[PC_W-1 -: 4])));
endmodule

// File: tb/pc_next_unit_bench.sv
`timescale 1ns/1ps
module pc_next_unit_bench;
    localparam logic [31:0] START = 32'h0040_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0;
    logic [31:0] instr = 32'h0;
    logic [31:0] rs_val = 32'h0;
    logic [31:0] rt_val = 32'h0;
    logic [31:0] pc;
    logic        taken;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model_pc = 32'h0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pc_next_unit #(.PC_W(32), .START_PC(START)) u_pc_next_unit (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .instr(instr),
        .rs_val(rs_val), .rt_val(rt_val), .pc(pc), .taken(taken)
    );

    function automatic bit ref_taken(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b);
        int op;
        op = int'(i[31:26]);
        if (op == 2) return 1'b1;
        if (op == 4) return a == b;
        if (op == 5) return a != b;
        return 1'b0;
    endfunction

    function automatic logic [31:0] ref_next(input logic [31:0] p, input logic [31:0] i,
                                             input logic [31:0] a, input logic [31:0] b);
        longint disp;
        int op;
        op = int'(i[31:26]);
        if (op == 2) return (p & 32'hF000_0000) | ({6'b0, i[25:0]} * 4);
        if (ref_taken(i, a, b)) begin
            disp = longint'($signed(i[15:0])) * 4;
            return 32'(longint'(p) + 4 + disp);
        end
        return p + 32'd4;
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b,
                         input logic en, input string tag);
        logic [31:0] exp_pc;
        @(negedge clk);
        instr = i; rs_val = a; rt_val = b; step_en = en;
        #1;
        check(tag, "taken", {31'b0, taken}, {31'b0, ref_taken(i, a, b)});
        exp_pc = en ? ref_next(model_pc, i, a, b) : model_pc;
        @(posedge clk);
        #1;
        check(tag, "pc", pc, exp_pc);
        model_pc = exp_pc;
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0; step_en = 1'b1; instr = 32'h0800_0123;
        @(posedge clk);
        #1;
        check(tag, "pc after reset", pc, START);
        model_pc = START;
        @(negedge clk);
        rst_n = 1'b1; step_en = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        do_reset("R1");
        drive(32'h00af_8020, 32'h1, 32'h2, 1'b1, "R3");             // register op
        drive(32'h8c48_0008, 32'h5, 32'h5, 1'b1, "R3");             // load op, equal operands ignored
        drive(32'h1000_0003, 32'h7, 32'h7, 1'b1, "R4");             // beq equal, +3 words
        drive(32'h1000_0003, 32'h7, 32'h8, 1'b1, "R5");             // beq unequal
        drive(32'h1400_fffe, 32'h1, 32'h2, 1'b1, "R6");             // bne differ, back 2 words
        drive(32'h1400_fffe, 32'h9, 32'h9, 1'b1, "R6");             // bne equal
        drive(32'h1000_fff0, 32'h3, 32'h3, 1'b1, "R8");             // backward branch
        drive(32'h1000_0040, 32'h4, 32'h4, 1'b0, "R2");             // no step, taken branch
        drive(32'h0800_0010, 32'h0, 32'h0, 1'b0, "R9");             // no step, jump still flags
        drive(32'h0bff_ffff, 32'h0, 32'h1, 1'b1, "R7");             // to 0x0FFFFFFC
        drive(32'h0800_0010, 32'h0, 32'h0, 1'b1, "R7");             // boundary jump
        drive(32'h1000_8000, 32'hA, 32'hA, 1'b1, "R10");            // most negative, wraps
        drive(32'h1400_8000, 32'h1, 32'h0, 1'b1, "R8");             // most negative again
        drive(32'h0000_0000, 32'h0, 32'h0, 1'b1, "R3");
        do_reset("R1");
        for (int k = 0; k < 200; k++) begin
            logic [31:0] w;
            logic [31:0] a;
            logic [31:0] b;
            int sel;
            sel = int'($urandom_range(0, 5));
            w = $urandom;
            case (sel)
                0: w[31:26] = 6'h02;
                1, 2: w[31:26] = 6'h04;
                3: w[31:26] = 6'h05;
                default: ;
            endcase
            a = $urandom_range(0, 3);
            b = $urandom_range(0, 3);
            drive(w, a, b, ($urandom_range(0, 4) != 0), "R4");
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule